// File: doc/BRIEF.md
# Two-Phase Recurrent Logarithmic Conversion Sequencer

This block is the digital controller of a logarithmic converter that works by successive approximation. The compensating level it builds has the form reference·ζ^k, so the whole search runs in the exponent k. An analog switched-capacitor path outside the block does three jobs: it multiplies a held level by one of several scaling coefficients, it keeps two alternating hold stores, and it compares the result against the input. The controller selects the coefficient, steers the hold stores and reads back one comparator bit each clock. A high bit means the trial level is still above the input.

A conversion runs in two phases. In the coarse phase the largest coefficient, with exponent weight 2^(NBITS-1), is applied again and again. Every step that passes is counted, up to a ceiling of P1_MAX passes. The first failing step is thrown away. In the fine phase the coefficients 2 to NBITS are each visited once, with weight 2^(NBITS-i). The fine phase can stop early against a programmable threshold. The code is the coarse count placed above the fine bits, and it is written into a result register with a one-cycle done pulse.

Top module: `rlog_seq`

States: `ST_IDLE` (waiting), `ST_LOAD` (reference loaded into the held store), `ST_COARSE` (repeated top coefficient), `ST_FINE` (single pass over the finer coefficients), `ST_LATCH` (result write). Transitions:
- IDLE→LOAD on `start`.
- LOAD→COARSE always.
- COARSE→COARSE on a pass below the ceiling.
- COARSE→FINE on a fail, or on the pass that reaches P1_MAX.
- FINE→FINE on a visited step that is not the last.
- FINE→LATCH after index NBITS, or on an early stop.
- LATCH→IDLE always.

## Requirements
- R1: When `start` is high in idle, the next edge clears `code` to 0, and the following cycle asserts `ref_load`. This loads the reference (exponent 0) into the store named by `mem_src`. The cycle after that is the first coarse step.
- R2: During the coarse phase `scale_sel`=1 (exponent weight 2^(NBITS-1)), `step_valid`, `coarse_sel_en` and `coarse_cnt_en` are high, and `fine_sel_en` is low. Each high comparator result adds one to the pass count.
- R3: The first low comparator result in the coarse phase ends that phase. That step is rejected: `mem_src` is unchanged, so the last passing level stays held.
- R4: When the pass count reaches P1_MAX, the block enters the fine phase without a failing step.
- R5: The fine phase presents `scale_sel` = 2, 3, … NBITS on consecutive cycles, each exactly once, with `fine_sel_en` high and the coarse enables low. Index i carries weight 2^(NBITS-i).
- R6: On any step, a high comparator result accepts the step: the level was written to `mem_dst`, and `mem_src` toggles on the next edge. A low result leaves `mem_src` unchanged. At done, the store named by `mem_src` holds exponent `code`.
- R7: `code` = n1·2^(NBITS-1) + Σ Ai·2^(NBITS-i) for i = 2..NBITS. In bits, this is the pass count in the upper bits and the fine bits in the lower NBITS-1 bits.
- R8: In the fine phase, if the weight of the current index is ≤ `err_thr`, no step is issued and the conversion finishes, leaving the remaining bits 0. `err_thr`=0 disables the early stop.
- R9: `done` rises c+f+2 edges after the edge that accepted `start`. Here c is the number of coarse steps: n1+1, or P1_MAX when saturated. f is the number of fine cycles: NBITS-1 with no early stop, otherwise the number of visited indices plus 1.
- R10: `done` is high for exactly one cycle, in the same cycle that `code` takes its new value. `code` then holds until the next accepted start.
- R11: A `start` pulse during a conversion is ignored. The result and the latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken only in idle |
| cmp_hi | input | 1 | Comparator: trial level still above the input |
| err_thr | input | NBITS-1 | Early-stop weight threshold (0 = off) |
| step_valid | output | 1 | A scaling step is applied this cycle |
| scale_sel | output | SELW | Selected scaling input, 1..NBITS (0 when none) |
| ref_load | output | 1 | Load the reference into the store named by mem_src |
| mem_src | output | 1 | Hold store that feeds the scaler |
| mem_dst | output | 1 | Hold store that receives the scaler output |
| coarse_sel_en | output | 1 | Coarse phase: top scaling input enabled |
| coarse_cnt_en | output | 1 | Coarse phase: pass counter enabled |
| fine_sel_en | output | 1 | Fine phase: inputs 2..NBITS enabled |
| result_wr_en | output | 1 | Fine phase and result write: result register enabled |
| code | output | CNTW+NBITS-1 | Conversion result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench models the analog path as exponent arithmetic. It updates its two hold stores on each edge, from `ref_load`, `mem_src`, `mem_dst` and the comparator bit, and it returns the comparator bit combinationally from the current `scale_sel`, so each step is resolved in the cycle it is presented. The cleared `code` and `ref_load` are checked in the cycle after the start edge. The coarse enables are checked one edge later. `done` is due exactly c+f+2 edges after the start edge, and the bench counts edges and compares that count with the table value. All samples are taken on the falling edge. The `done` pulse is checked for having fallen, with `code` held, one cycle after it rose.

// File: rtl/rlog_pkg.sv
package rlog_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COARSE,
        ST_FINE,
        ST_LATCH
    } rlog_state_e;
endpackage

// File: rtl/rlog_coarse_cnt.sv
module rlog_coarse_cnt #(
    parameter int P1_MAX = 15,
    parameter int CNTW   = $clog2(P1_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    output logic [CNTW-1:0] cnt,
    output logic            last
);
    localparam logic [CNTW-1:0] LAST_V = CNTW'(P1_MAX - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // the next pass reaches the ceiling
    assign last = (cnt == LAST_V);
endmodule

// File: rtl/rlog_fine_walk.sv
module rlog_fine_walk #(
    parameter int NBITS = 10,
    parameter int SELW  = $clog2(NBITS + 1),
    parameter int AW    = NBITS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic            acc_en,
    output logic [SELW-1:0] idx,
    output logic [AW-1:0]   weight,
    output logic [AW-1:0]   acc,
    output logic            at_end
);
    localparam logic [SELW-1:0] FIRST_IDX = SELW'(2);
    localparam logic [SELW-1:0] LAST_IDX  = SELW'(NBITS);
    localparam logic [AW-1:0]   ONE       = AW'(1);

    logic [SELW-1:0] shamt;

    assign shamt  = LAST_IDX - idx;
    assign weight = ONE << shamt;
    assign at_end = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= FIRST_IDX;
            acc <= '0;
        end else if (clr) begin
            idx <= FIRST_IDX;
            acc <= '0;
        end else begin
            if (adv && !at_end)
                idx <= idx + 1'b1;
            if (acc_en)
                acc <= acc + weight;
        end
    end
endmodule

// File: rtl/rlog_pingpong.sv
module rlog_pingpong (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic swap,
    output logic src,
    output logic dst
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            src <= 1'b0;
        else if (clr)
            src <= 1'b0;
        else if (swap)
            src <= ~src;
    end

    assign dst = ~src;
endmodule

// File: rtl/rlog_seq.sv
module rlog_seq
    import rlog_pkg::*;
#(
    parameter int NBITS  = 10,
    parameter int P1_MAX = 15,
    parameter int SELW   = $clog2(NBITS + 1),
    parameter int CNTW   = $clog2(P1_MAX + 1),
    parameter int CW     = CNTW + NBITS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hi,
    input  logic [NBITS-2:0] err_thr,
    output logic             step_valid,
    output logic [SELW-1:0]  scale_sel,
    output logic             ref_load,
    output logic             mem_src,
    output logic             mem_dst,
    output logic             coarse_sel_en,
    output logic             coarse_cnt_en,
    output logic             fine_sel_en,
    output logic             result_wr_en,
    output logic [CW-1:0]    code,
    output logic             done
);
    localparam int AW = NBITS - 1;

    rlog_state_e     state_q, state_d;
    logic            clr;
    logic            inc;
    logic            cnt_last;
    logic [CNTW-1:0] cnt;
    logic            adv;
    logic            acc_en;
    logic [SELW-1:0] fine_idx;
    logic [AW-1:0]   fine_w;
    logic [AW-1:0]   fine_acc;
    logic            fine_end;
    logic            stop_now;
    logic            swap;
    logic            done_q;
    logic [CW-1:0]   code_q;

    rlog_coarse_cnt #(.P1_MAX(P1_MAX), .CNTW(CNTW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    rlog_fine_walk #(.NBITS(NBITS), .SELW(SELW), .AW(AW)) u_fine (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .adv    (adv),
        .acc_en (acc_en),
        .idx    (fine_idx),
        .weight (fine_w),
        .acc    (fine_acc),
        .at_end (fine_end)
    );

    rlog_pingpong u_pp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .swap  (swap),
        .src   (mem_src),
        .dst   (mem_dst)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_COARSE;
            ST_COARSE: begin
                if (!cmp_hi || cnt_last)
                    state_d = ST_FINE;
            end
            ST_FINE: begin
                if (stop_now || fine_end)
                    state_d = ST_LATCH;
            end
            ST_LATCH:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        clr           = 1'b0;
        ref_load      = 1'b0;
        step_valid    = 1'b0;
        scale_sel     = '0;
        coarse_sel_en = 1'b0;
        coarse_cnt_en = 1'b0;
        fine_sel_en   = 1'b0;
        result_wr_en  = 1'b0;
        stop_now      = 1'b0;
        inc           = 1'b0;
        adv           = 1'b0;
        acc_en        = 1'b0;
        unique case (state_q)
            ST_IDLE:   clr = start;
            ST_LOAD:   ref_load = 1'b1;
            ST_COARSE: begin
                step_valid    = 1'b1;
                scale_sel     = SELW'(1);
                coarse_sel_en = 1'b1;
                coarse_cnt_en = 1'b1;
                inc           = cmp_hi;
            end
            ST_FINE: begin
                fine_sel_en  = 1'b1;
                result_wr_en = 1'b1;
                stop_now     = (fine_w <= err_thr);
                step_valid   = !stop_now;
                scale_sel    = stop_now ? '0 : fine_idx;
                adv          = !stop_now;
                acc_en       = !stop_now && cmp_hi;
            end
            ST_LATCH:  result_wr_en = 1'b1;
            default:   ;
        endcase
    end

    assign swap = step_valid && cmp_hi;

    // result register and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_LATCH);
            if (clr)
                code_q <= '0;
            else if (state_q == ST_LATCH)
                code_q <= {cnt, fine_acc};
        end
    end

    assign code = code_q;
    assign done = done_q;
endmodule

// File: rtl/rlog_seq_chk.sv
module rlog_seq_chk #(
    parameter int SELW = 4,
    parameter int CW   = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmp_hi,
    input logic            step_valid,
    input logic [SELW-1:0] scale_sel,
    input logic            ref_load,
    input logic            mem_src,
    input logic            coarse_sel_en,
    input logic            fine_sel_en,
    input logic [CW-1:0]   code,
    input logic            done
);
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(coarse_sel_en && fine_sel_en)); // R5

    AST_COARSE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_sel_en |-> (scale_sel == SELW'(1)) && step_valid); // R2

    AST_COARSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_sel_en && !cmp_hi |=> !coarse_sel_en); // R3

    AST_FINE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        fine_sel_en && step_valid |-> scale_sel >= SELW'(2)); // R5

    AST_FINE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        fine_sel_en && step_valid && $past(fine_sel_en && step_valid)
        |-> scale_sel == $past(scale_sel) + 1'b1); // R5

    AST_HOLD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid && !cmp_hi |=> $stable(mem_src)); // R6

    AST_HOLD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid && cmp_hi |=> mem_src != $past(mem_src)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> (done || ref_load)); // R10
endmodule

bind rlog_seq rlog_seq_chk #(.SELW(SELW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_hi        (cmp_hi),
    .step_valid    (step_valid),
    .scale_sel     (scale_sel),
    .ref_load      (ref_load),
    .mem_src       (mem_src),
    .coarse_sel_en (coarse_sel_en),
    .fine_sel_en   (fine_sel_en),
    .code          (code),
    .done          (done)
);

// File: tb/rlog_seq_test.sv
module rlog_seq_test;
    localparam int NB   = 10;
    localparam int PMAX = 15;
    localparam int SELW = $clog2(NB + 1);
    localparam int CNTW = $clog2(PMAX + 1);
    localparam int CW   = CNTW + NB - 1;
    localparam int NV   = 11;

    // input exponent, threshold, expected code, expected latency (edges)
    localparam int VK [NV] = '{0, 1536, 1700, 511, 5000, 9000, 7780, 1700, 1700, 1023, 7679};
    localparam int VT [NV] = '{0,    0,    0,   0,    0,    0,    0,   15,  255, 1000,    0};
    localparam int VC [NV] = '{0, 1536, 1700, 511, 5000, 8191, 7780, 1696, 1536,  512, 7679};
    localparam int VL [NV] = '{12,  15,   15,  12,   21,   26,   26,   12,    8,    5,   26};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            cmp_hi;
    logic [NB-2:0]   err_thr = '0;
    logic            step_valid;
    logic [SELW-1:0] scale_sel;
    logic            ref_load;
    logic            mem_src;
    logic            mem_dst;
    logic            coarse_sel_en;
    logic            coarse_cnt_en;
    logic            fine_sel_en;
    logic            result_wr_en;
    logic [CW-1:0]   code;
    logic            done;

    int total = 0;
    int bad   = 0;
    int k_in  = 0;
    int em [2];
    int trial;
    int ticks = 0;

    always #10 clk = ~clk;

    rlog_seq #(.NBITS(NB), .P1_MAX(PMAX)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cmp_hi        (cmp_hi),
        .err_thr       (err_thr),
        .step_valid    (step_valid),
        .scale_sel     (scale_sel),
        .ref_load      (ref_load),
        .mem_src       (mem_src),
        .mem_dst       (mem_dst),
        .coarse_sel_en (coarse_sel_en),
        .coarse_cnt_en (coarse_cnt_en),
        .fine_sel_en   (fine_sel_en),
        .result_wr_en  (result_wr_en),
        .code          (code),
        .done          (done)
    );

    // analog path model in the exponent domain
    always_comb begin
        trial = em[mem_src] + (1 << (NB - int'(scale_sel)));
        cmp_hi = step_valid && (trial <= k_in);
    end

    always @(posedge clk) begin
        if (ref_load)
            em[mem_src] <= 0;
        else if (step_valid && cmp_hi)
            em[mem_dst] <= trial;
    end

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", ticks);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int k, input int thr, input int exp_code,
                       input int exp_lat, input int poke_at);
        int cyc;
        k_in = k;
        err_thr = (NB-1)'(thr);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(code == '0, "R1 code cleared", int'(code), 0);
        check(ref_load == 1'b1, "R1 ref_load", int'(ref_load), 1);
        start = 1'b0;
        cyc = 0;
        while (cyc < 200) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = (cyc == poke_at);
            if (cyc == 1)
                check(coarse_sel_en && coarse_cnt_en && !fine_sel_en && scale_sel == SELW'(1),
                      "R2 coarse enables", int'(scale_sel), 1);
            if (done) break;
        end
        start = 1'b0;
        check(cyc == exp_lat, "R9 latency", cyc, exp_lat);
        check(int'(code) == exp_code, "R7 code", int'(code), exp_code);
        check(em[mem_src] == int'(code), "R6 held exponent", em[mem_src], int'(code));
        @(negedge clk);
        check(!done && int'(code) == exp_code, "R10 done pulse and hold", int'(done), 0);
    endtask

    initial begin
        em[0] = 0;
        em[1] = 0;
        repeat (3) @(negedge clk);
        check(code == '0 && !done, "R10 reset code/done", int'(code), 0);
        check(!step_valid && !coarse_sel_en && !fine_sel_en && !result_wr_en,
              "R1 reset idle", int'(step_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R3 fail ends coarse (0,1536,5000), R4 saturation (9000,7780),
        // R5 full fine pass, R8 early stop (thr 15/255/1000)
        for (int i = 0; i < NV; i++) begin
            run(VK[i], VT[i], VC[i], VL[i], -1);
            repeat (2) @(negedge clk);
        end

        // R11: start pulse mid-coarse and mid-fine are ignored
        run(1700, 0, 1700, 15, 2);
        run(1700, 0, 1700, 15, 8);

        // R8: threshold just below the smallest weight keeps all bits
        run(1700, 0, 1700, 15, -1);
        // R4: exactly P1_MAX passes with zero remainder
        run(7680, 0, 7680, 26, -1);

        // R5: fine phase select sequence observed at the ports
        k_in = 300;
        err_thr = '0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!fine_sel_en) @(negedge clk);
        for (int j = 2; j <= NB; j++) begin
            check(int'(scale_sel) == j && fine_sel_en && !coarse_sel_en,
                  "R5 fine order", int'(scale_sel), j);
            @(negedge clk);
        end
        while (!done) @(negedge clk);
        check(int'(code) == 300, "R7 code 300", int'(code), 300);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule